// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block keeps the status flags of an integer datapath in deferred form. When an ALU operation completes, the datapath does not hand over finished flags. It hands over an operation tag, a width code, both operands (the second operand doubles as the shift count) and the result. The block latches these in a single clock. Zero, sign, parity, overflow and auxiliary carry are then derived combinationally from the stored context whenever they are read. For shifts this covers overflow as well, which comes from the saved original operand and the count rather than from a bit fixed at execute time.

Carry is different. It lives in an explicit six-bit flag register that software-visible state can also load directly. A direct load switches the block into an "unknown" mode, and in that mode every flag output simply mirrors the explicit register. For shift tags the block works out the carry itself when the context is recorded: it is the last bit shifted out. For add and subtract the carry comes in from the datapath, and for logic results it is cleared.

Top module: `deferred_flag_unit`

## Requirements
- R1: A synchronous active-high reset puts the block in unknown mode and clears the explicit register, so every flag output reads 0 from the first cycle after reset.
- R2: When `wr_en` is high, the explicit register loads `wr_flags` and the block enters unknown mode. In unknown mode each output equals its register bit: bit 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow. A write takes priority over a record in the same cycle.
- R3: For every recorded tag, zero is 1 exactly when the result bits inside the active width are all 0. Width codes: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits.
- R4: For every recorded tag, sign is result bit 7, 15 or 31, chosen by the width code.
- R5: For every recorded tag, parity is 1 when result bits 7..0 hold an even number of ones, whatever the width.
- R6: For add (tag code 1), overflow is the top bit at the active width of ~(a^b)&(a^result), and auxiliary is bit 4 of a^b^result.
- R7: For subtract (tag code 2), overflow is the top bit of (a^b)&(a^result), and auxiliary is bit 4 of a^b^result.
- R8: For a logical left shift (tag code 3), overflow is the top bit at the active width of (a shifted left by count) XOR (a shifted left by count-1).
- R9: For a logical right shift (tag code 4), overflow is 1 only when the count is exactly 1 and the top bit of a at the active width is 1.
- R10: For an arithmetic right shift (tag code 5) and for logic results (tag code 0), overflow reads 0. Auxiliary reads 0 for all three shift tags and for logic results.
- R11: When a shift is recorded, carry becomes the last bit shifted out of a at the active width. The count is `rec_b[CNT_W-1:0]`. A left or logical right shift past the width gives 0, and an arithmetic right shift past the width gives the sign bit.
- R12: When add or subtract is recorded, carry takes `rec_carry`. When a logic result is recorded, carry is cleared.
- R13: A record with tag code 6 or 7, or a shift record with count 0, changes nothing: all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_en | input | 1 | Record strobe for an ALU context |
| rec_kind | input | 3 | Tag code: 0 logic, 1 add, 2 sub, 3 shl, 4 shr, 5 sar |
| rec_size | input | 2 | Width code: 0 byte, 1 half, 2/3 word |
| rec_a | input | 32 | First operand / operand before shift |
| rec_b | input | 32 | Second operand or shift count (low CNT_W bits) |
| rec_res | input | 32 | Result of the operation |
| rec_carry | input | 1 | Carry from the datapath for add/sub |
| wr_en | input | 1 | Direct load of the explicit flag register |
| wr_flags | input | 6 | Value for the explicit flag register |
| flag_carry | output | 1 | Carry flag |
| flag_parity | output | 1 | Parity flag |
| flag_aux | output | 1 | Auxiliary carry flag |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The bench builds the block with the default CNT_W of 5, so shift counts span 0 to 31. That range reaches counts larger than the 8-bit and 16-bit widths, where left and logical right shifts lose every bit and arithmetic shifts saturate to the sign. It also covers count 1, the only count at which a logical right shift can report overflow, and count 31 on full words. Counts of 32 or more lie outside what this build can reach.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    localparam int DATA_W = 32;
    localparam int NFLAG  = 6;

    localparam int FB_C = 0;
    localparam int FB_P = 1;
    localparam int FB_A = 2;
    localparam int FB_Z = 3;
    localparam int FB_S = 4;
    localparam int FB_O = 5;

    typedef enum logic [2:0] {
        K_LOGIC = 3'd0,
        K_ADD   = 3'd1,
        K_SUB   = 3'd2,
        K_SHL   = 3'd3,
        K_SHR   = 3'd4,
        K_SAR   = 3'd5,
        K_RSV   = 3'd6,
        K_UNK   = 3'd7
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [1:0]        size;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] r;
    } ctx_t;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] size);
        case (size)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [1:0] size);
        case (size)
            2'd0:    return v[7];
            2'd1:    return v[15];
            default: return v[DATA_W-1];
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sign_ext(input logic [DATA_W-1:0] v, input logic [1:0] size);
        case (size)
            2'd0:    return {{(DATA_W-8){v[7]}}, v[7:0]};
            2'd1:    return {{(DATA_W-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/dfe_shift_carry.sv
module dfe_shift_carry
    import dfe_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  kind_e             kind,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    output logic              carry
);
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] right_v;
    logic [DATA_W-1:0] arith_v;

    always_comb begin
        a_m     = a & size_mask(size);
        step    = DATA_W'(cnt) - DATA_W'(1);
        left_v  = a_m << step;
        right_v = a_m >> step;
        arith_v = DATA_W'($signed(sign_ext(a, size)) >>> step);
        case (kind)
            K_SHL:   carry = top_bit(left_v, size);
            K_SHR:   carry = right_v[0];
            K_SAR:   carry = arith_v[0];
            default: carry = 1'b0;
        endcase
    end
endmodule

// File: rtl/dfe_flag_derive.sv
module dfe_flag_derive
    import dfe_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  ctx_t             ctx,
    input  logic [NFLAG-1:0] xflags,
    output logic [NFLAG-1:0] flags
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] sh_now;
    logic [DATA_W-1:0] sh_prev;
    logic [DATA_W-1:0] half_x;
    logic [DATA_W-1:0] ovf_add;
    logic [DATA_W-1:0] ovf_sub;

    always_comb begin
        mask    = size_mask(ctx.size);
        cnt     = DATA_W'(ctx.b[CNT_W-1:0]);
        sh_now  = ctx.a << cnt;
        sh_prev = ctx.a << (cnt - DATA_W'(1));
        half_x  = ctx.a ^ ctx.b ^ ctx.r;
        ovf_add = ~(ctx.a ^ ctx.b) & (ctx.a ^ ctx.r);
        ovf_sub = (ctx.a ^ ctx.b) & (ctx.a ^ ctx.r);

        flags       = '0;
        flags[FB_C] = xflags[FB_C];
        if (ctx.kind == K_UNK || ctx.kind == K_RSV) begin
            flags = xflags;
        end else begin
            flags[FB_Z] = ((ctx.r & mask) == '0);
            flags[FB_S] = top_bit(ctx.r, ctx.size);
            flags[FB_P] = ~^ctx.r[7:0];
            case (ctx.kind)
                K_ADD: begin
                    flags[FB_O] = top_bit(ovf_add, ctx.size);
                    flags[FB_A] = half_x[4];
                end
                K_SUB: begin
                    flags[FB_O] = top_bit(ovf_sub, ctx.size);
                    flags[FB_A] = half_x[4];
                end
                K_SHL:   flags[FB_O] = top_bit(sh_now ^ sh_prev, ctx.size);
                K_SHR:   flags[FB_O] = (cnt == DATA_W'(1)) && top_bit(ctx.a, ctx.size);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/deferred_flag_unit.sv
module deferred_flag_unit
    import dfe_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rec_en,
    input  logic [2:0]  rec_kind,
    input  logic [1:0]  rec_size,
    input  logic [31:0] rec_a,
    input  logic [31:0] rec_b,
    input  logic [31:0] rec_res,
    input  logic        rec_carry,
    input  logic        wr_en,
    input  logic [5:0]  wr_flags,
    output logic        flag_carry,
    output logic        flag_parity,
    output logic        flag_aux,
    output logic        flag_zero,
    output logic        flag_sign,
    output logic        flag_ovf
);
    typedef struct packed {
        ctx_t             ctx;
        logic [NFLAG-1:0] x;
    } state_t;

    state_t            st_d, st_q;
    kind_e             rk;
    logic              rk_shift;
    logic              rk_valid;
    logic              rec_ok;
    logic [CNT_W-1:0]  rec_cnt;
    logic              sh_carry;
    logic [NFLAG-1:0]  flg;

    assign rk       = kind_e'(rec_kind);
    assign rec_cnt  = rec_b[CNT_W-1:0];
    assign rk_shift = (rk == K_SHL) || (rk == K_SHR) || (rk == K_SAR);
    assign rk_valid = (rk != K_RSV) && (rk != K_UNK);

    dfe_shift_carry #(.CNT_W(CNT_W)) u_shc (
        .kind  (rk),
        .size  (rec_size),
        .a     (rec_a),
        .cnt   (rec_cnt),
        .carry (sh_carry)
    );

    always_comb begin
        st_d   = st_q;
        rec_ok = rec_en && rk_valid && !(rk_shift && rec_cnt == '0);
        if (wr_en) begin
            st_d.x        = wr_flags;
            st_d.ctx.kind = K_UNK;
        end else if (rec_ok) begin
            st_d.ctx.kind = rk;
            st_d.ctx.size = rec_size;
            st_d.ctx.a    = rec_a;
            st_d.ctx.b    = rec_b;
            st_d.ctx.r    = rec_res;
            if (rk_shift)
                st_d.x[FB_C] = sh_carry;
            else if (rk == K_LOGIC)
                st_d.x[FB_C] = 1'b0;
            else
                st_d.x[FB_C] = rec_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.ctx.kind <= K_UNK;
        end else begin
            st_q <= st_d;
        end
    end

    dfe_flag_derive #(.CNT_W(CNT_W)) u_drv (
        .ctx    (st_q.ctx),
        .xflags (st_q.x),
        .flags  (flg)
    );

    assign flag_carry  = flg[FB_C];
    assign flag_parity = flg[FB_P];
    assign flag_aux    = flg[FB_A];
    assign flag_zero   = flg[FB_Z];
    assign flag_sign   = flg[FB_S];
    assign flag_ovf    = flg[FB_O];

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (flg == '0));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flg == $past(wr_flags)));

    a_r9_shr_count_one: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctx.kind == K_SHR && st_q.ctx.b[CNT_W-1:0] != CNT_W'(1)) |-> !flg[FB_O]);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctx.kind == K_SAR || st_q.ctx.kind == K_LOGIC) |-> !flg[FB_O]);

    a_r10_no_aux: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctx.kind inside {K_SHL, K_SHR, K_SAR, K_LOGIC}) |-> !flg[FB_A]);

    a_r13_ignored_record: assert property (@(posedge clk) disable iff (rst)
        (rec_en && !wr_en && (!rk_valid || (rk_shift && rec_cnt == '0))) |=> $stable(flg));
endmodule

// File: tb/tb_deferred_flag_unit.sv
module tb_deferred_flag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        rec_en;
    logic [2:0]  rec_kind;
    logic [1:0]  rec_size;
    logic [31:0] rec_a, rec_b, rec_res;
    logic        rec_carry;
    logic        wr_en;
    logic [5:0]  wr_flags;
    logic        flag_carry, flag_parity, flag_aux, flag_zero, flag_sign, flag_ovf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model of the stored context
    int          m_kind;
    int          m_size;
    logic [31:0] m_a, m_b, m_r;
    logic [5:0]  m_x;

    always #10 clk = ~clk;

    deferred_flag_unit dut (
        .clk(clk), .rst(rst), .rec_en(rec_en), .rec_kind(rec_kind), .rec_size(rec_size),
        .rec_a(rec_a), .rec_b(rec_b), .rec_res(rec_res), .rec_carry(rec_carry),
        .wr_en(wr_en), .wr_flags(wr_flags),
        .flag_carry(flag_carry), .flag_parity(flag_parity), .flag_aux(flag_aux),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf)
    );

    function automatic int wbits(input int size);
        return (size == 0) ? 8 : (size == 1) ? 16 : 32;
    endfunction

    // last shifted-out bit and final value, one step at a time
    function automatic logic [32:0] shift_walk(input int kind, input int size,
                                               input logic [31:0] a, input int cnt);
        int          w = wbits(size);
        logic [31:0] t = 0;
        logic        c = 1'b0;
        logic        sg;
        for (int i = 0; i < w; i++) t[i] = a[i];
        sg = t[w-1];
        for (int k = 0; k < cnt; k++) begin
            if (kind == 3) begin
                c = t[w-1];
                t = t << 1;
                if (w < 32) t[w] = 1'b0;
                for (int j = w + 1; j < 32; j++) t[j] = 1'b0;
            end else begin
                c = t[0];
                t = t >> 1;
                if (kind == 5) t[w-1] = sg;
            end
        end
        return {c, t};
    endfunction

    function automatic logic [5:0] expect_flags();
        logic [5:0]  e = 0;
        int          w = wbits(m_size);
        int          ones = 0;
        logic        zero = 1'b1;
        logic [32:0] sw;
        if (m_kind == 7) return m_x;
        for (int i = 0; i < w; i++) if (m_r[i]) zero = 1'b0;
        for (int i = 0; i < 8; i++) if (m_r[i]) ones++;
        e[0] = m_x[0];
        e[3] = zero;
        e[4] = m_r[w-1];
        e[1] = (ones % 2 == 0);
        case (m_kind)
            1: begin
                e[5] = (m_a[w-1] == m_b[w-1]) && (m_r[w-1] != m_a[w-1]);
                e[2] = ({1'b0, m_a[3:0]} + {1'b0, m_b[3:0]}) > 5'd15;
            end
            2: begin
                e[5] = (m_a[w-1] != m_b[w-1]) && (m_r[w-1] != m_a[w-1]);
                e[2] = m_a[3:0] < m_b[3:0];
            end
            3: begin
                sw   = shift_walk(3, m_size, m_a, int'(m_b[4:0]));
                e[5] = sw[w-1] ^ sw[32];
            end
            4: e[5] = (m_b[4:0] == 5'd1) && m_a[w-1];
            default: ;
        endcase
        return e;
    endfunction

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, nm, act, exp);
        end
    endtask

    task automatic compare(input bit ignored);
        logic [5:0] e = expect_flags();
        string rz = "R3", rs = "R4", rp = "R5", rc, ro, ra;
        rc = (m_kind >= 3 && m_kind <= 5) ? "R11" : "R12";
        case (m_kind)
            1: begin ro = "R6"; ra = "R6"; end
            2: begin ro = "R7"; ra = "R7"; end
            3: begin ro = "R8"; ra = "R10"; end
            4: begin ro = "R9"; ra = "R10"; end
            default: begin ro = "R10"; ra = "R10"; end
        endcase
        if (m_kind == 7) begin rz = "R2"; rs = "R2"; rp = "R2"; rc = "R2"; ro = "R2"; ra = "R2"; end
        if (ignored)     begin rz = "R13"; rs = "R13"; rp = "R13"; rc = "R13"; ro = "R13"; ra = "R13"; end
        chk(rc, "carry",  flag_carry,  e[0]);
        chk(rp, "parity", flag_parity, e[1]);
        chk(ra, "aux",    flag_aux,    e[2]);
        chk(rz, "zero",   flag_zero,   e[3]);
        chk(rs, "sign",   flag_sign,   e[4]);
        chk(ro, "ovf",    flag_ovf,    e[5]);
    endtask

    task automatic step(input bit wr, input logic [5:0] wf, input bit rec, input int kind,
                        input int size, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] r, input logic cin);
        bit          is_sh = (kind >= 3 && kind <= 5);
        bit          ok    = rec && kind < 6 && !(is_sh && b[4:0] == 5'd0);
        logic [32:0] sw;
        wr_en = wr; wr_flags = wf; rec_en = rec;
        rec_kind = 3'(kind); rec_size = 2'(size);
        rec_a = a; rec_b = b; rec_res = r; rec_carry = cin;
        if (wr) begin
            m_x = wf; m_kind = 7;
        end else if (ok) begin
            m_kind = kind; m_size = size; m_a = a; m_b = b; m_r = r;
            if (is_sh) begin
                sw = shift_walk(kind, size, a, int'(b[4:0]));
                m_x[0] = sw[32];
            end else if (kind == 0) m_x[0] = 1'b0;
            else m_x[0] = cin;
        end
        @(posedge clk);
        #2;
        wr_en = 1'b0; rec_en = 1'b0;
        compare(!wr && rec && !ok);
    endtask

    task automatic rec_op(input int kind, input int size, input logic [31:0] a,
                          input logic [31:0] b, input logic cin);
        logic [31:0] r;
        logic [32:0] sw;
        case (kind)
            1: r = a + b;
            2: r = a - b;
            3, 4, 5: begin sw = shift_walk(kind, size, a, int'(b[4:0])); r = sw[31:0]; end
            default: r = a & b;
        endcase
        step(1'b0, 6'd0, 1'b1, kind, size, a, b, r, cin);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        rst = 1'b1; rec_en = 0; wr_en = 0; wr_flags = 0; rec_kind = 0; rec_size = 0;
        rec_a = 0; rec_b = 0; rec_res = 0; rec_carry = 0;
        m_kind = 7; m_size = 0; m_a = 0; m_b = 0; m_r = 0; m_x = 0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: reset state
        chk("R1", "all", |{flag_carry, flag_parity, flag_aux, flag_zero, flag_sign, flag_ovf}, 1'b0);

        // R2: direct load and unknown mode
        step(1'b1, 6'b101010, 1'b0, 0, 0, 0, 0, 0, 0);
        step(1'b1, 6'b010101, 1'b0, 0, 0, 0, 0, 0, 0);
        // R8/R11: byte left shift by 1 with carry and overflow
        rec_op(3, 0, 32'h81, 32'd1, 0);
        // R9: logical right shift, count 1 versus 2
        rec_op(4, 0, 32'h80, 32'd1, 0);
        rec_op(4, 0, 32'h80, 32'd2, 0);
        // R11: arithmetic shift past the half width
        rec_op(5, 1, 32'h0000_8000, 32'd20, 0);
        rec_op(3, 0, 32'hFF, 32'd12, 0);
        rec_op(5, 2, 32'h8000_0001, 32'd31, 0);
        // R13: zero count and reserved codes
        step(1'b0, 0, 1'b1, 3, 0, 32'h55, 32'h20, 32'h0, 0);
        step(1'b0, 0, 1'b1, 6, 2, 32'h1, 32'h1, 32'h0, 1);
        step(1'b0, 0, 1'b1, 7, 1, 32'h1, 32'h1, 32'h0, 1);
        // R2: write beats record in the same cycle
        step(1'b1, 6'b111111, 1'b1, 1, 0, 32'h1, 32'h1, 32'h2, 0);
        // R6/R7: signed overflow at 8 and 32 bits
        rec_op(1, 0, 32'h7F, 32'h01, 0);
        rec_op(2, 2, 32'h8000_0000, 32'h1, 1);
        rec_op(2, 1, 32'h0000_0003, 32'h4, 1);
        // R3: zero with nonzero bits above width
        step(1'b0, 0, 1'b1, 0, 0, 32'h0, 32'h0, 32'hFF00, 0);
        rec_op(0, 1, 32'hF0F0, 32'h0F0F, 0);

        for (int it = 0; it < 600; it++) begin
            int          k  = int'($urandom % 8);
            int          sz = int'($urandom % 4);
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            if (k >= 3 && k <= 5) b = ($urandom % 4 == 0) ? 32'd1 : ($urandom % 32);
            if ($urandom % 10 == 0)
                step(1'b1, 6'($urandom), 1'($urandom), k, sz, a, b, $urandom, 1'($urandom));
            else if (k == 0 && $urandom % 4 == 0)
                step(1'b0, 0, 1'b1, 0, sz, a, b, 32'h0, 0);
            else if (k >= 6)
                step(1'b0, 0, 1'b1, k, sz, a, b, $urandom, 1'($urandom));
            else
                rec_op(k, sz, a, b, 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule